// File: doc/BRIEF.md
# Banked Execution Priority Resolver

This block produces the running execution priority of an interrupt controller that keeps separate secure and non-secure copies of its masking state. Each state has its own base-priority threshold, its own global interrupt mask and its own fault mask, and each bank has its own group-priority mask. Two control bits change how the non-secure masks take effect. The first bit moves non-secure priorities into the lower half of the range. The second bit hands ownership of fault handling to the non-secure state.

The masks are not ranked by a fixed precedence. Six steps act on one running value in a fixed order. Each step can leave the value as it is, lower it, cap it or replace it. The result of the six steps is then limited by the priority of the active handler. Logic downstream compares the registered output with pending exceptions.

Priorities are signed 10-bit values. Smaller numbers are more urgent. The value 256 means that no exception is running.

Top module: `exec_prio_resolver`

## Requirements
- R1: While `rstN` is low at a rising clock edge, `runPrio` becomes 256 (the no-exception level) after that edge.
- R2: `runPrio` is registered. It shows the result for the inputs sampled at the previous rising edge. With no mask set, no nonzero base priority and `activePrio` = 256, it is 256.
- R3: A nonzero `nsBasepri` sets the running value to `nsBasepri & nsGroupMask`. When `nsPrioLower` is 1, that masked value is mapped to (masked >> 1) + 128 instead. A zero `nsBasepri` has no effect.
- R4: A nonzero `sBasepri` gives a group priority of `sBasepri & sGroupMask`. This group priority replaces the running value only when it is numerically smaller, so it never raises the value. A zero `sBasepri` has no effect.
- R5: `nsPrimask` = 1 caps the running value at 128 when `nsPrioLower` = 1. It forces the value to 0 when `nsPrioLower` = 0.
- R6: `sPrimask` = 1 forces the running value to 0.
- R7: `nsFaultmask` = 1 forces the running value to -1 when `nsFaultOwn` = 1. When `nsFaultOwn` = 0, it acts exactly like R5.
- R8: `sFaultmask` = 1 forces the running value to -3 when `nsFaultOwn` = 1, and to -1 when `nsFaultOwn` = 0.
- R9: The steps apply in this order, each acting on the result of the one before: R3, R4, R5, R6, R7, R8.
- R10: `runPrio` is the smaller of the R9 result and `activePrio`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| nsBasepri | input | 8 | Non-secure base priority threshold |
| sBasepri | input | 8 | Secure base priority threshold |
| nsPrimask | input | 1 | Non-secure global interrupt mask |
| sPrimask | input | 1 | Secure global interrupt mask |
| nsFaultmask | input | 1 | Non-secure fault mask |
| sFaultmask | input | 1 | Secure fault mask |
| nsPrioLower | input | 1 | Moves non-secure priorities into the lower half of the range |
| nsFaultOwn | input | 1 | Non-secure state owns fault handling |
| nsGroupMask | input | 8 | Group-priority mask for the non-secure bank |
| sGroupMask | input | 8 | Group-priority mask for the secure bank |
| activePrio | input | 10 | Signed priority of the active handler (256 when none) |
| runPrio | output | 10 | Signed running execution priority |

## Verification
Three kinds of effect can meet in one cycle: the secure base-priority comparison, a non-secure cap to 128, and the limit set by the active handler. For example, a secure threshold below 128 together with a non-secure mask under the lower-priority bit must keep the secure value and must not be raised to 128. The bench drives these collisions both from its vector table and from a sweep over all 256 combinations of the mask and control bits with several threshold and handler values. Each result is compared, one clock later, with a model that applies the steps one after another.

// File: rtl/prio_pkg.sv
package prio_pkg;

  // Strobes from control to datapath: which override each step applies.
  typedef struct packed {
    logic nsBaseEn;    // non-secure threshold step active
    logic nsScaled;    // non-secure threshold mapped into lower half
    logic sBaseEn;     // secure threshold step active
    logic nsPmCap;     // non-secure interrupt mask caps at half range
    logic nsPmZero;    // non-secure interrupt mask forces zero
    logic sPmZero;     // secure interrupt mask forces zero
    logic nsFmCap;     // non-secure fault mask caps at half range
    logic nsFmZero;    // non-secure fault mask forces zero
    logic nsFmMinus1;  // non-secure fault mask forces -1
    logic sFmMinus1;   // secure fault mask forces -1
    logic sFmMinus3;   // secure fault mask forces -3
  } mask_strobes_t;

endpackage

// File: rtl/prio_ctrl.sv
module prio_ctrl
  import prio_pkg::*;
#(
  parameter int PRIO_W = 8
) (
  input  logic [PRIO_W-1:0] nsBasepri,
  input  logic [PRIO_W-1:0] sBasepri,
  input  logic              nsPrimask,
  input  logic              sPrimask,
  input  logic              nsFaultmask,
  input  logic              sFaultmask,
  input  logic              nsPrioLower,
  input  logic              nsFaultOwn,
  output mask_strobes_t     ctl
);

  always_comb begin
    ctl            = '0;
    ctl.nsBaseEn   = |nsBasepri;
    ctl.nsScaled   = nsPrioLower;
    ctl.sBaseEn    = |sBasepri;
    ctl.nsPmCap    = nsPrimask & nsPrioLower;
    ctl.nsPmZero   = nsPrimask & ~nsPrioLower;
    ctl.sPmZero    = sPrimask;
    ctl.nsFmMinus1 = nsFaultmask & nsFaultOwn;
    ctl.nsFmCap    = nsFaultmask & ~nsFaultOwn & nsPrioLower;
    ctl.nsFmZero   = nsFaultmask & ~nsFaultOwn & ~nsPrioLower;
    ctl.sFmMinus3  = sFaultmask & nsFaultOwn;
    ctl.sFmMinus1  = sFaultmask & ~nsFaultOwn;
  end

endmodule

// File: rtl/prio_datapath.sv
module prio_datapath
  import prio_pkg::*;
#(
  parameter int PRIO_W = 8,
  localparam int RW = PRIO_W + 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  mask_strobes_t        ctl,
  input  logic [PRIO_W-1:0]    nsBasepri,
  input  logic [PRIO_W-1:0]    sBasepri,
  input  logic [PRIO_W-1:0]    nsGroupMask,
  input  logic [PRIO_W-1:0]    sGroupMask,
  input  logic signed [RW-1:0] activePrio,
  output logic signed [RW-1:0] runPrio
);

  localparam logic signed [RW-1:0] NOEXC_V = RW'(1 << PRIO_W);
  localparam logic signed [RW-1:0] CAP_V   = RW'(1 << (PRIO_W - 1));
  localparam logic signed [RW-1:0] ZERO_V  = '0;
  localparam logic signed [RW-1:0] M1_V    = -RW'(1);
  localparam logic signed [RW-1:0] M3_V    = -RW'(3);
  localparam int NSTEP = 7;

  logic [PRIO_W-1:0]    nsMasked, sMasked;
  logic signed [RW-1:0] nsGrp, sGrp, resolved;
  logic signed [RW-1:0] step [NSTEP];

  function automatic logic signed [RW-1:0] capOrZero(
    input logic signed [RW-1:0] cur, input logic doCap, input logic doZero);
    if (doZero)                  return ZERO_V;
    if (doCap && (cur > CAP_V))  return CAP_V;
    return cur;
  endfunction

  assign nsMasked = nsBasepri & nsGroupMask;
  assign sMasked  = sBasepri & sGroupMask;
  assign nsGrp = ctl.nsScaled ? (RW'(nsMasked >> 1) + CAP_V) : RW'(nsMasked);
  assign sGrp  = RW'(sMasked);

  // Override chain, one stage per mask, in the fixed order.
  always_comb begin
    step[0] = NOEXC_V;
    step[1] = ctl.nsBaseEn ? nsGrp : step[0];
    step[2] = (ctl.sBaseEn && (sGrp < step[1])) ? sGrp : step[1];
    step[3] = capOrZero(step[2], ctl.nsPmCap, ctl.nsPmZero);
    step[4] = ctl.sPmZero ? ZERO_V : step[3];
    step[5] = ctl.nsFmMinus1 ? M1_V : capOrZero(step[4], ctl.nsFmCap, ctl.nsFmZero);
    step[6] = ctl.sFmMinus3 ? M3_V : (ctl.sFmMinus1 ? M1_V : step[5]);
    resolved = (activePrio < step[6]) ? activePrio : step[6];
  end

  always_ff @(posedge clk) begin
    if (!rstN) runPrio <= NOEXC_V;
    else       runPrio <= resolved;
  end

  a_r1_reset_level: assert property (@(posedge clk)
    !rstN |=> runPrio == NOEXC_V);

  a_r8_secure_fault_owned: assert property (@(posedge clk) disable iff (!rstN)
    ctl.sFmMinus3 |=> runPrio <= M3_V);

  a_r8_secure_fault_kept: assert property (@(posedge clk) disable iff (!rstN)
    ctl.sFmMinus1 |=> runPrio <= M1_V);

  a_r6_secure_primask: assert property (@(posedge clk) disable iff (!rstN)
    ctl.sPmZero |=> runPrio <= ZERO_V);

  a_r5_ns_cap: assert property (@(posedge clk) disable iff (!rstN)
    ctl.nsPmCap |=> runPrio <= CAP_V);

  a_r10_handler_bound: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> runPrio <= $past(activePrio));

endmodule

// File: rtl/exec_prio_resolver.sv
module exec_prio_resolver
  import prio_pkg::*;
#(
  parameter int PRIO_W = 8,
  localparam int RW = PRIO_W + 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PRIO_W-1:0]    nsBasepri,
  input  logic [PRIO_W-1:0]    sBasepri,
  input  logic                 nsPrimask,
  input  logic                 sPrimask,
  input  logic                 nsFaultmask,
  input  logic                 sFaultmask,
  input  logic                 nsPrioLower,
  input  logic                 nsFaultOwn,
  input  logic [PRIO_W-1:0]    nsGroupMask,
  input  logic [PRIO_W-1:0]    sGroupMask,
  input  logic signed [RW-1:0] activePrio,
  output logic signed [RW-1:0] runPrio
);

  mask_strobes_t ctl;

  prio_ctrl #(.PRIO_W(PRIO_W)) ctrl_i (
    .nsBasepri   (nsBasepri),
    .sBasepri    (sBasepri),
    .nsPrimask   (nsPrimask),
    .sPrimask    (sPrimask),
    .nsFaultmask (nsFaultmask),
    .sFaultmask  (sFaultmask),
    .nsPrioLower (nsPrioLower),
    .nsFaultOwn  (nsFaultOwn),
    .ctl         (ctl)
  );

  prio_datapath #(.PRIO_W(PRIO_W)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .nsBasepri   (nsBasepri),
    .sBasepri    (sBasepri),
    .nsGroupMask (nsGroupMask),
    .sGroupMask  (sGroupMask),
    .activePrio  (activePrio),
    .runPrio     (runPrio)
  );

endmodule

// File: tb/exec_prio_resolver_tb_top.sv
`timescale 1ns/1ps
module exec_prio_resolver_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] nsBasepri = '0, sBasepri = '0, nsGroupMask = 8'hFF, sGroupMask = 8'hFF;
  logic nsPrimask = 0, sPrimask = 0, nsFaultmask = 0, sFaultmask = 0;
  logic nsPrioLower = 0, nsFaultOwn = 0;
  logic signed [9:0] activePrio = 10'sd256;
  logic signed [9:0] runPrio;

  int nChecks = 0;
  int nFails = 0;
  bit doneFlag = 0;

  always #2.5 clk = ~clk;

  exec_prio_resolver dut_i (
    .clk(clk), .rstN(rstN), .nsBasepri(nsBasepri), .sBasepri(sBasepri),
    .nsPrimask(nsPrimask), .sPrimask(sPrimask), .nsFaultmask(nsFaultmask),
    .sFaultmask(sFaultmask), .nsPrioLower(nsPrioLower), .nsFaultOwn(nsFaultOwn),
    .nsGroupMask(nsGroupMask), .sGroupMask(sGroupMask),
    .activePrio(activePrio), .runPrio(runPrio)
  );

  // masks field order: {nsPm, sPm, nsFm, sFm}
  typedef struct packed {
    logic [7:0] nsBp;
    logic [7:0] sBp;
    logic [7:0] nsGm;
    logic [7:0] sGm;
    logic [3:0] masks;
    logic       lower;
    logic       own;
    logic signed [9:0] act;
    logic signed [9:0] exp;
    logic [7:0] tag;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{8'h00, 8'h00, 8'hFF, 8'hFF, 4'b0000, 1'b0, 1'b0, 10'sd256, 10'sd256, 8'd2},  // R2
    '{8'h40, 8'h00, 8'hFF, 8'hFF, 4'b0000, 1'b0, 1'b0, 10'sd256, 10'sd64,  8'd3},  // R3
    '{8'h40, 8'h00, 8'hFF, 8'hFF, 4'b0000, 1'b1, 1'b0, 10'sd256, 10'sd160, 8'd3},  // R3 scaled
    '{8'h47, 8'h00, 8'hF0, 8'hFF, 4'b0000, 1'b0, 1'b0, 10'sd256, 10'sd64,  8'd3},  // R3 grouped
    '{8'h40, 8'h60, 8'hFF, 8'hFF, 4'b0000, 1'b0, 1'b0, 10'sd256, 10'sd64,  8'd4},  // R4 no raise
    '{8'h40, 8'h20, 8'hFF, 8'hFF, 4'b0000, 1'b0, 1'b0, 10'sd256, 10'sd32,  8'd4},  // R4 lowers
    '{8'h00, 8'h35, 8'hFF, 8'hE0, 4'b0000, 1'b0, 1'b0, 10'sd256, 10'sd32,  8'd4},  // R4 grouped
    '{8'h00, 8'h00, 8'hFF, 8'hFF, 4'b1000, 1'b1, 1'b0, 10'sd256, 10'sd128, 8'd5},  // R5 cap
    '{8'h00, 8'h30, 8'hFF, 8'hFF, 4'b1000, 1'b1, 1'b0, 10'sd256, 10'sd48,  8'd5},  // R5 cap keeps lower
    '{8'h40, 8'h00, 8'hFF, 8'hFF, 4'b1000, 1'b0, 1'b0, 10'sd256, 10'sd0,   8'd5},  // R5 zero
    '{8'h00, 8'h00, 8'hFF, 8'hFF, 4'b0100, 1'b1, 1'b0, 10'sd256, 10'sd0,   8'd6},  // R6
    '{8'h00, 8'h00, 8'hFF, 8'hFF, 4'b0010, 1'b0, 1'b1, 10'sd256, -10'sd1,  8'd7},  // R7 owned
    '{8'h00, 8'h00, 8'hFF, 8'hFF, 4'b0010, 1'b1, 1'b0, 10'sd256, 10'sd128, 8'd7},  // R7 cap
    '{8'h00, 8'h00, 8'hFF, 8'hFF, 4'b0010, 1'b0, 1'b0, 10'sd256, 10'sd0,   8'd7},  // R7 zero
    '{8'h00, 8'h00, 8'hFF, 8'hFF, 4'b0001, 1'b0, 1'b1, 10'sd256, -10'sd3,  8'd8},  // R8 owned
    '{8'h00, 8'h00, 8'hFF, 8'hFF, 4'b0001, 1'b0, 1'b0, 10'sd256, -10'sd1,  8'd8},  // R8 kept
    '{8'h00, 8'h00, 8'hFF, 8'hFF, 4'b0011, 1'b0, 1'b0, 10'sd256, -10'sd1,  8'd9},  // R9
    '{8'h00, 8'h00, 8'hFF, 8'hFF, 4'b0101, 1'b0, 1'b1, 10'sd256, -10'sd3,  8'd9},  // R9
    '{8'h80, 8'h90, 8'hFF, 8'hFF, 4'b0000, 1'b1, 1'b0, 10'sd256, 10'sd144, 8'd9},  // R9 secure below scaled
    '{8'h40, 8'h00, 8'hFF, 8'hFF, 4'b0000, 1'b0, 1'b0, 10'sd16,  10'sd16,  8'd10}, // R10
    '{8'h00, 8'h00, 8'hFF, 8'hFF, 4'b0000, 1'b0, 1'b0, -10'sd1,  -10'sd1,  8'd10}, // R10
    '{8'h40, 8'h00, 8'hFF, 8'hFF, 4'b0000, 1'b0, 1'b0, 10'sd80,  10'sd64,  8'd10}  // R10
  };

  function automatic int refPrio(int nsBp, int sBp, int nsGm, int sGm,
                                 bit nsPm, bit sPm, bit nsFm, bit sFm,
                                 bit lower, bit own, int act);
    int r = 256;
    int g;
    if (nsBp > 0) begin
      g = nsBp & nsGm;
      if (lower) g = (g >> 1) + 128;
      r = g;
    end
    if (sBp > 0) begin
      g = sBp & sGm;
      if (g < r) r = g;
    end
    if (nsPm) r = lower ? ((r > 128) ? 128 : r) : 0;
    if (sPm) r = 0;
    if (nsFm) begin
      if (own) r = -1;
      else r = lower ? ((r > 128) ? 128 : r) : 0;
    end
    if (sFm) r = own ? -3 : -1;
    return (r < act) ? r : act;
  endfunction

  task automatic check(string req, int got, int exp);
    nChecks++;
    if (got != exp) begin
      nFails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic drive(logic [7:0] a, logic [7:0] b, logic [7:0] c, logic [7:0] d,
                       logic [3:0] m, logic lo, logic ow, logic signed [9:0] ac);
    nsBasepri = a; sBasepri = b; nsGroupMask = c; sGroupMask = d;
    {nsPrimask, sPrimask, nsFaultmask, sFaultmask} = m;
    nsPrioLower = lo; nsFaultOwn = ow; activePrio = ac;
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!doneFlag) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      finishRun();
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", runPrio, 256);
    rstN = 1'b1;

    // Vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i].nsBp, VECS[i].sBp, VECS[i].nsGm, VECS[i].sGm, VECS[i].masks,
            VECS[i].lower, VECS[i].own, VECS[i].act);
      @(posedge clk);
      @(negedge clk);
      check($sformatf("R%0d vec%0d", VECS[i].tag, i), runPrio, VECS[i].exp);
    end

    // Sweep of all mask/control bits with several thresholds (R3-R10)
    for (int combo = 0; combo < 256; combo++) begin
      for (int p = 0; p < 3; p++) begin
        logic [7:0] a, b, c, d;
        logic signed [9:0] ac;
        a = 8'((combo * 37 + p * 91) & 255);
        b = 8'((combo * 53 + p * 29 + 7) & 255);
        c = (p == 1) ? 8'hE0 : 8'hFF;
        d = (p == 2) ? 8'hC0 : 8'hFF;
        ac = (p == 0) ? 10'sd256 : ((p == 1) ? 10'sd96 : -10'sd1);
        if (combo[0]) a = 8'h00;
        if (combo[1]) b = 8'h00;
        @(negedge clk);
        drive(a, b, c, d, 4'(combo >> 2), combo[6], combo[7], ac);
        @(posedge clk);
        @(negedge clk);
        check("R9 sweep", runPrio,
              refPrio(a, b, c, d, combo[2+3], combo[2+2], combo[2+1], combo[2],
                      combo[6], combo[7], ac));
      end
    end

    // R2: one-cycle latency, old value held until the edge
    @(negedge clk);
    drive(8'h00, 8'h00, 8'hFF, 8'hFF, 4'b0000, 1'b0, 1'b0, 10'sd256);
    @(posedge clk);
    @(negedge clk);
    check("R2 idle", runPrio, 256);
    drive(8'h00, 8'h00, 8'hFF, 8'hFF, 4'b0100, 1'b0, 1'b0, 10'sd256);
    #1;
    check("R2 before edge", runPrio, 256);
    @(posedge clk);
    @(negedge clk);
    check("R2 after edge", runPrio, 0);

    // R1: reset mid-run overrides secure fault mask
    drive(8'h00, 8'h00, 8'hFF, 8'hFF, 4'b0001, 1'b0, 1'b1, 10'sd256);
    rstN = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R1 mid-run", runPrio, 256);
    rstN = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R8 after reset", runPrio, -3);

    // R4: zero secure threshold ignored even when its mask would give 0
    drive(8'h50, 8'h00, 8'hFF, 8'h00, 4'b0000, 1'b0, 1'b0, 10'sd256);
    @(posedge clk);
    @(negedge clk);
    check("R4 zero ignored", runPrio, 80);

    // R3: nonzero threshold masked to zero still sets 0
    drive(8'h0F, 8'h00, 8'hF0, 8'hFF, 4'b0000, 1'b0, 1'b0, 10'sd256);
    @(posedge clk);
    @(negedge clk);
    check("R3 masked to zero", runPrio, 0);

    doneFlag = 1;
    finishRun();
  end

endmodule